// File: doc/BRIEF.md
# Exception Entry Sequencer with Fault Escalation

This block carries a processor from the moment an exception is raised to the moment its handler may start. When a raise strobe arrives with an exception vector, the sequencer saves the interrupted instruction pointer and flags word to a downward-growing stack. It then fetches the 16-byte gate descriptor for that vector from a descriptor table, in two 64-bit reads. After checking the descriptor it updates the flags word and the code segment and presents the handler address as the new instruction pointer, marking completion with a one-cycle done strobe.

Entry can fail. A descriptor whose present bit is clear, or a fault reported on the fault input while entry is under way, abandons the current entry and restarts it on the double-fault vector. A second failure while that double-fault entry is running is unrecoverable. The block then raises a reset request and freezes until its reset is applied. The interrupt stack index and privilege level fields of the descriptor are passed out untouched.

The table is read through a synchronous port: data for an address requested in one cycle appears on `tbl_rdata_i` in the next. The stack is written through a single write port, one 64-bit word per cycle.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset, busy_o, done_o, reset_req_o, stk_we_o and tbl_req_o are 0, and ip_o, flags_o, cs_o, sp_o, ist_o and dpl_o are 0.
- R2: In the first cycle after a raise is accepted the block writes the saved IP to address sp_i-8. In the next cycle it writes the saved FLAGS to the address 8 lower again. sp_o follows each write. A write is suppressed in a cycle where fault_i is high.
- R3: Only after both pushes, the block issues two table reads on consecutive cycles: first TBL_BASE + 16*vector, then that address + 8.
- R4: In the first word read, bits 15:0 hold handler[15:0], bits 31:16 the selector, bits 47:32 the options word and bits 63:48 handler[31:16]. Bits 31:0 of the second word hold handler[63:32]. When done_o is high, ip_o equals the handler address and cs_o equals the selector.
- R5: Options bit 8 equal to 0 makes flags_o the saved FLAGS with bit 9 cleared. Bit 8 equal to 1 makes flags_o equal to the saved FLAGS.
- R6: A descriptor with options bit 15 equal to 0 abandons the entry and restarts it on vector 8, pushing IP and FLAGS again below the current stack pointer.
- R7: fault_i high during any entry cycle from the first push through the load cycle restarts the entry on vector 8.
- R8: A restart condition (R6 or R7) during an entry on vector 8 started by escalation sets reset_req_o. The block then keeps reset_req_o high, never asserts done_o, stk_we_o or tbl_req_o, and ignores raise_i until reset.
- R9: When done_o is high, ist_o equals options bits 2:0 and dpl_o equals options bits 14:13.
- R10: raise_i is ignored while busy_o is high. busy_o is high from the first push cycle through the done cycle.
- R11: done_o is a one-cycle pulse two cycles after the check cycle. A successful entry clears the double-fault state, so a later restart condition again escalates only to a double fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| raise_i | input | 1 | Exception raise strobe, sampled when idle |
| vector_i | input | VEC_W | Exception vector |
| fault_i | input | 1 | Fault reported during entry |
| ip_i | input | 64 | Interrupted instruction pointer |
| flags_i | input | 64 | Interrupted flags word |
| sp_i | input | ADDR_W | Stack pointer at the raise |
| tbl_req_o | output | 1 | Table read request |
| tbl_addr_o | output | ADDR_W | Table read byte address |
| tbl_rdata_i | input | 64 | Table read data, one cycle after request |
| stk_we_o | output | 1 | Stack write enable |
| stk_addr_o | output | ADDR_W | Stack write byte address |
| stk_wdata_o | output | 64 | Stack write data |
| ip_o | output | 64 | Handler address |
| flags_o | output | 64 | Updated flags word |
| cs_o | output | 16 | Loaded code segment selector |
| sp_o | output | ADDR_W | Current stack pointer |
| ist_o | output | 3 | Interrupt stack index from descriptor |
| dpl_o | output | 2 | Privilege level from descriptor |
| busy_o | output | 1 | Entry in progress |
| done_o | output | 1 | Entry completed |
| reset_req_o | output | 1 | Triple fault reset request |

## Verification
The bench targets restarts that land on awkward cycles. A fault during the flags push must not emit that write, or the stack would hold a stray word and the restarted pushes would sit one slot off. A not-present descriptor must restart on vector 8 rather than jump to a garbage handler. A failure inside the double-fault entry must halt with a reset request. A block that forgot to clear its double-fault state after success would halt where it should only escalate once. Trap and interrupt gates are run back to back to catch an inverted or misplaced interrupt-enable bit, and a raise held high during entry would otherwise hijack the vector.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned WORD_W = 64;
  localparam int unsigned SEL_W  = 16;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PUSH_IP, ST_PUSH_FL, ST_RD_LO, ST_RD_HI,
    ST_CHECK, ST_LOAD, ST_DONE, ST_HALT
  } ent_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] handler;
    logic [SEL_W-1:0]  sel;
    logic              present;
    logic              trap;
    logic [2:0]        ist;
    logic [1:0]        dpl;
  } desc_t;
endpackage

// File: rtl/exc_desc_decode.sv
module exc_desc_decode
  import exc_entry_pkg::*;
(
  input  logic [WORD_W-1:0] lo_i,
  input  logic [WORD_W-1:0] hi_i,
  output desc_t             desc_o
);
  logic [15:0] opt;
  logic        unused_bits;

  assign opt = lo_i[47:32];

  always_comb begin
    desc_o.handler = {hi_i[31:0], lo_i[63:48], lo_i[15:0]};
    desc_o.sel     = lo_i[31:16];
    desc_o.present = opt[15];
    desc_o.trap    = opt[8];
    desc_o.ist     = opt[2:0];
    desc_o.dpl     = opt[14:13];
  end

  assign unused_bits = ^{hi_i[63:32], opt[12:9], opt[7:3]};
endmodule

// File: rtl/exc_fault_escalate.sv
module exc_fault_escalate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fault_req_i,
  input  logic entry_ok_i,
  output logic in_double_o,
  output logic to_double_o,
  output logic to_triple_o
);
  logic dbl_q;

  assign to_double_o = fault_req_i && !dbl_q;
  assign to_triple_o = fault_req_i &&  dbl_q;
  assign in_double_o = dbl_q;

  // sticky until a handler entry completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          dbl_q <= 1'b0;
    else if (entry_ok_i)  dbl_q <= 1'b0;
    else if (to_double_o) dbl_q <= 1'b1;
  end
endmodule

// File: rtl/exc_stack_ptr.sv
module exc_stack_ptr #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned STEP   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              push_i,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] push_addr_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);
  logic [ADDR_W-1:0] sp_q;

  assign push_addr_o = sp_q - STEP_V;
  assign sp_o        = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (load_i) sp_q <= load_val_i;
    else if (push_i) sp_q <= push_addr_o;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int unsigned       VEC_W    = 8,
  parameter int unsigned       ADDR_W   = 64,
  parameter logic [ADDR_W-1:0] TBL_BASE = ADDR_W'('h1000),
  parameter int unsigned       DF_VEC   = 8,
  parameter int unsigned       IE_BIT   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raise_i,
  input  logic [VEC_W-1:0]  vector_i,
  input  logic              fault_i,
  input  logic [63:0]       ip_i,
  input  logic [63:0]       flags_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              tbl_req_o,
  output logic [ADDR_W-1:0] tbl_addr_o,
  input  logic [63:0]       tbl_rdata_i,
  output logic              stk_we_o,
  output logic [ADDR_W-1:0] stk_addr_o,
  output logic [63:0]       stk_wdata_o,
  output logic [63:0]       ip_o,
  output logic [63:0]       flags_o,
  output logic [15:0]       cs_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [2:0]        ist_o,
  output logic [1:0]        dpl_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              reset_req_o
);
  localparam int unsigned       WBYTES  = WORD_W / 8;
  localparam int unsigned       SLOT_SH = $clog2(2 * WBYTES);
  localparam logic [VEC_W-1:0]  DF_V    = VEC_W'(DF_VEC);

  ent_state_e        state_q, state_d;
  logic [VEC_W-1:0]  vec_q;
  logic [WORD_W-1:0] sv_ip_q, sv_fl_q, lo_q, hi_q, ip_q, fl_q;
  logic [SEL_W-1:0]  cs_q;
  logic [2:0]        ist_q;
  logic [1:0]        dpl_q;
  desc_t             desc;
  logic              in_entry, fault_hit, to_double, to_triple, in_double;
  logic              accept, push_en;
  logic [ADDR_W-1:0] push_addr;

  exc_desc_decode u_dec (.lo_i(lo_q), .hi_i(hi_q), .desc_o(desc));

  exc_fault_escalate u_esc (
    .clk_i, .rst_ni,
    .fault_req_i (fault_hit),
    .entry_ok_i  (state_q == ST_DONE),
    .in_double_o (in_double),
    .to_double_o (to_double),
    .to_triple_o (to_triple)
  );

  exc_stack_ptr #(.ADDR_W(ADDR_W), .STEP(WBYTES)) u_sp (
    .clk_i, .rst_ni,
    .load_i      (accept),
    .load_val_i  (sp_i),
    .push_i      (push_en),
    .sp_o        (sp_o),
    .push_addr_o (push_addr)
  );

  assign accept   = (state_q == ST_IDLE) && raise_i;
  assign in_entry = state_q inside {ST_PUSH_IP, ST_PUSH_FL, ST_RD_LO, ST_RD_HI, ST_CHECK, ST_LOAD};
  assign fault_hit = in_entry && (fault_i || (state_q == ST_CHECK && !desc.present));
  assign push_en  = (state_q == ST_PUSH_IP || state_q == ST_PUSH_FL) && !fault_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (raise_i) state_d = ST_PUSH_IP;
      ST_PUSH_IP: state_d = ST_PUSH_FL;
      ST_PUSH_FL: state_d = ST_RD_LO;
      ST_RD_LO:   state_d = ST_RD_HI;
      ST_RD_HI:   state_d = ST_CHECK;
      ST_CHECK:   state_d = ST_LOAD;
      ST_LOAD:    state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      ST_HALT:    state_d = ST_HALT;
      default:    state_d = ST_IDLE;
    endcase
    if (fault_hit) state_d = to_triple ? ST_HALT : ST_PUSH_IP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q   <= '0;
      sv_ip_q <= '0;
      sv_fl_q <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else begin
      if (accept) begin
        vec_q   <= vector_i;
        sv_ip_q <= ip_i;
        sv_fl_q <= flags_i;
      end
      if (to_double)              vec_q <= DF_V;
      if (state_q == ST_RD_HI)    lo_q  <= tbl_rdata_i;
      if (state_q == ST_CHECK)    hi_q  <= tbl_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ip_q  <= '0;
      fl_q  <= '0;
      cs_q  <= '0;
      ist_q <= '0;
      dpl_q <= '0;
    end else if (state_q == ST_LOAD && !fault_hit) begin
      ip_q  <= desc.handler;
      cs_q  <= desc.sel;
      ist_q <= desc.ist;
      dpl_q <= desc.dpl;
      fl_q  <= sv_fl_q;
      if (!desc.trap) fl_q[IE_BIT] <= 1'b0;
    end
  end

  assign stk_we_o    = push_en;
  assign stk_addr_o  = push_addr;
  assign stk_wdata_o = (state_q == ST_PUSH_IP) ? sv_ip_q : sv_fl_q;

  assign tbl_req_o  = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
  assign tbl_addr_o = TBL_BASE + (ADDR_W'(vec_q) << SLOT_SH)
                    + ((state_q == ST_RD_HI) ? ADDR_W'(WBYTES) : '0);

  assign ip_o        = ip_q;
  assign flags_o     = fl_q;
  assign cs_o        = cs_q;
  assign ist_o       = ist_q;
  assign dpl_o       = dpl_q;
  assign busy_o      = in_entry || state_q == ST_DONE;
  assign done_o      = state_q == ST_DONE;
  assign reset_req_o = state_q == ST_HALT;

  logic unused_dbl;
  assign unused_dbl = in_double;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int unsigned ADDR_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              raise_i,
  input logic              stk_we_o,
  input logic [ADDR_W-1:0] stk_addr_o,
  input logic              tbl_req_o,
  input logic [ADDR_W-1:0] tbl_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              reset_req_o
);
  AST_READ_AFTER_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tbl_req_o) |-> $past(stk_we_o)); // R3
  AST_PUSH_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stk_we_o && $past(stk_we_o)) |-> stk_addr_o == $past(stk_addr_o) - ADDR_W'(8)); // R2
  AST_READ_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tbl_req_o && $past(tbl_req_o)) |-> tbl_addr_o == $past(tbl_addr_o) + ADDR_W'(8)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |=> reset_req_o); // R8
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> !(done_o || stk_we_o || tbl_req_o || busy_o)); // R8
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && raise_i) |=> busy_o || reset_req_o); // R10
endmodule

bind exc_entry_seq exc_entry_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .raise_i(raise_i),
  .stk_we_o(stk_we_o), .stk_addr_o(stk_addr_o),
  .tbl_req_o(tbl_req_o), .tbl_addr_o(tbl_addr_o),
  .busy_o(busy_o), .done_o(done_o), .reset_req_o(reset_req_o)
);

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;
  localparam logic [63:0] BASE = 64'h1000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        raise = 1'b0, fault = 1'b0;
  logic [7:0]  vec = '0;
  logic [63:0] ip_in = '0, fl_in = '0, sp_in = '0, rdata = '0;
  logic        tbl_req, stk_we, busy, done, rreq;
  logic [63:0] tbl_addr, stk_addr, stk_wdata, ip_o, fl_o, sp_o;
  logic [15:0] cs_o;
  logic [2:0]  ist_o;
  logic [1:0]  dpl_o;

  logic [63:0] tbl [0:63];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit  ended = 0;

  always #10 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk_i(clk), .rst_ni(rst_n), .raise_i(raise), .vector_i(vec), .fault_i(fault),
    .ip_i(ip_in), .flags_i(fl_in), .sp_i(sp_in),
    .tbl_req_o(tbl_req), .tbl_addr_o(tbl_addr), .tbl_rdata_i(rdata),
    .stk_we_o(stk_we), .stk_addr_o(stk_addr), .stk_wdata_o(stk_wdata),
    .ip_o(ip_o), .flags_o(fl_o), .cs_o(cs_o), .sp_o(sp_o), .ist_o(ist_o), .dpl_o(dpl_o),
    .busy_o(busy), .done_o(done), .reset_req_o(rreq));

  // synchronous table read, one cycle latency
  always @(posedge clk) begin
    if (tbl_req) begin
      int idx;
      idx = int'((tbl_addr - BASE) >> 3);
      rdata <= (idx >= 0 && idx < 64) ? tbl[idx] : 64'hdead_beef_dead_beef;
    end
  end

  function automatic logic [63:0] mk_lo(logic [63:0] h, logic [15:0] sel, bit p, bit trap,
                                        logic [2:0] ist, logic [1:0] dpl);
    logic [15:0] opt;
    opt = {p, dpl, 1'b0, 3'b111, trap, 5'b0, ist};
    return {h[31:16], opt, sel, h[15:0]};
  endfunction

  task automatic set_desc(int v, logic [63:0] h, logic [15:0] sel, bit p, bit trap,
                          logic [2:0] ist, logic [1:0] dpl);
    tbl[2*v]   = mk_lo(h, sel, p, trap, ist, dpl);
    tbl[2*v+1] = {32'hffff_ffff, h[63:32]};
  endtask

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference model: 0 idle,1 push ip,2 push fl,3 rd lo,4 rd hi,5 check,6 load,7 done,8 halt
  int          m_st;
  logic [7:0]  m_vec;
  logic [63:0] m_sp, m_sip, m_sfl, m_ip, m_fl;
  logic [15:0] m_cs;
  logic [2:0]  m_ist;
  logic [1:0]  m_dpl;
  bit          m_dbl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_vec = 0; m_sp = 0; m_sip = 0; m_sfl = 0;
      m_ip = 0; m_fl = 0; m_cs = 0; m_ist = 0; m_dpl = 0; m_dbl = 0;
    end else begin
      bit fail_now;
      logic [63:0] lo, hi;
      lo = tbl[2*m_vec];
      hi = tbl[2*m_vec+1];
      fail_now = (m_st >= 1 && m_st <= 6) && (fault || (m_st == 5 && !lo[47]));
      if ((m_st == 1 || m_st == 2) && !fault) m_sp = m_sp - 8;
      if (fail_now) begin
        if (m_dbl) m_st = 8;
        else begin m_dbl = 1; m_vec = 8; m_st = 1; end
      end else begin
        case (m_st)
          0: if (raise) begin
               m_st = 1; m_vec = vec; m_sip = ip_in; m_sfl = fl_in; m_sp = sp_in;
             end
          6: begin
               m_ip = {hi[31:0], lo[63:48], lo[15:0]};
               m_cs = lo[31:16]; m_ist = lo[34:32]; m_dpl = lo[46:45];
               m_fl = m_sfl;
               if (!lo[40]) m_fl[9] = 1'b0;
               m_st = 7;
             end
          7: begin m_st = 0; m_dbl = 0; end
          8: m_st = 8;
          default: m_st = m_st + 1;
        endcase
      end
    end
  end

  // compare mid high phase each cycle
  always @(posedge clk) begin
    #5;
    if (rst_n && !ended) begin
      bit e_we, e_req;
      e_we  = (m_st == 1 || m_st == 2) && !fault;
      e_req = (m_st == 3 || m_st == 4);
      chk(stk_we == e_we, "R2", "stk_we", 64'(stk_we), 64'(e_we));
      if (e_we) begin
        chk(stk_addr == m_sp - 8, "R2", "stk_addr", stk_addr, m_sp - 8);
        chk(stk_wdata == (m_st == 1 ? m_sip : m_sfl), "R2", "stk_wdata", stk_wdata,
            m_st == 1 ? m_sip : m_sfl);
      end
      chk(sp_o == m_sp, "R2", "sp", sp_o, m_sp);
      chk(tbl_req == e_req, "R3", "tbl_req", 64'(tbl_req), 64'(e_req));
      if (e_req)
        chk(tbl_addr == BASE + 64'(m_vec) * 16 + (m_st == 4 ? 8 : 0), "R3", "tbl_addr",
            tbl_addr, BASE + 64'(m_vec) * 16 + (m_st == 4 ? 8 : 0));
      chk(ip_o == m_ip, "R4", "ip", ip_o, m_ip);
      chk(cs_o == m_cs, "R4", "cs", 64'(cs_o), 64'(m_cs));
      chk(fl_o == m_fl, "R5", "flags", fl_o, m_fl);
      chk(ist_o == m_ist && dpl_o == m_dpl, "R9", "ist/dpl", {59'b0, ist_o, dpl_o},
          {59'b0, m_ist, m_dpl});
      chk(busy == (m_st >= 1 && m_st <= 7), "R10", "busy", 64'(busy),
          64'(m_st >= 1 && m_st <= 7));
      chk(done == (m_st == 7), "R11", "done", 64'(done), 64'(m_st == 7));
      chk(rreq == (m_st == 8), "R8", "reset_req", 64'(rreq), 64'(m_st == 8));
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  // f1/f2: negedge index after the raise at which fault pulses (-1 none)
  task automatic run_entry(logic [7:0] v, logic [63:0] ip, logic [63:0] fl, logic [63:0] sp,
                           int f1, int f2, bit hold_raise);
    @(negedge clk);
    raise = 1; vec = v; ip_in = ip; fl_in = fl; sp_in = sp;
    for (int k = 1; k < 60; k++) begin
      @(negedge clk);
      raise = hold_raise; vec = v + 8'd1; ip_in = ~ip;
      fault = (k == f1 || k == f2);
      if (done || rreq) break;
    end
    raise = 0; fault = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) tbl[i] = '0;
    set_desc(14, 64'h1234_5678_9abc_def0, 16'h0010, 1, 0, 3'd2, 2'd0);
    set_desc(6,  64'h0000_7fff_0000_4000, 16'h0018, 1, 1, 3'd0, 2'd3);
    set_desc(8,  64'hffff_8000_dddd_0800, 16'h0008, 1, 0, 3'd1, 2'd0);
    set_desc(3,  64'h0,                   16'h0000, 0, 0, 3'd0, 2'd0);
    set_desc(5,  64'h5555_0000_aaaa_1111, 16'h0020, 1, 1, 3'd7, 2'd2);

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !rreq && !stk_we && !tbl_req, "R1", "ctrl after reset",
        {59'b0, busy, done, rreq, stk_we, tbl_req}, 64'd0);
    chk(ip_o == 0 && fl_o == 0 && cs_o == 0 && sp_o == 0 && ist_o == 0 && dpl_o == 0,
        "R1", "data after reset", ip_o | fl_o | sp_o, 64'd0);
    rst_n = 1;
    @(negedge clk);

    // R4 R5 interrupt gate clears bit 9
    run_entry(8'd14, 64'h0000_0000_0040_1000, 64'h0000_0000_0000_0202, 64'h8000, -1, -1, 0);
    chk(ip_o == 64'h1234_5678_9abc_def0, "R4", "handler vec14", ip_o, 64'h1234_5678_9abc_def0);
    chk(fl_o == 64'h0002, "R5", "IE cleared", fl_o, 64'h0002);
    chk(ist_o == 3'd2, "R9", "ist vec14", 64'(ist_o), 64'd2);

    // R5 R9 R10 trap gate keeps flags, raise held high during entry
    run_entry(8'd6, 64'h0000_0000_0040_2000, 64'h0000_0000_0000_0a46, 64'h7000, -1, -1, 1);
    chk(fl_o == 64'h0a46, "R5", "trap keeps flags", fl_o, 64'h0a46);
    chk(dpl_o == 2'd3 && cs_o == 16'h0018, "R9", "dpl/cs vec6", {46'b0, dpl_o, cs_o}, 64'h3_0018);
    chk(ip_o == 64'h0000_7fff_0000_4000, "R10", "held raise ignored", ip_o, 64'h0000_7fff_0000_4000);
    repeat (3) @(negedge clk);

    // R6 not present -> double fault on vector 8
    run_entry(8'd3, 64'h0000_0000_0040_3000, 64'h0200, 64'h6000, -1, -1, 0);
    chk(ip_o == 64'hffff_8000_dddd_0800, "R6", "double handler", ip_o, 64'hffff_8000_dddd_0800);
    chk(sp_o == 64'h6000 - 32, "R6", "four pushes", sp_o, 64'h6000 - 32);
    // R11 double state cleared: repeat escalates only once
    run_entry(8'd3, 64'h0000_0000_0040_3100, 64'h0200, 64'h6000, -1, -1, 0);
    chk(done === 1'b1 || ip_o == 64'hffff_8000_dddd_0800, "R11", "second double ok",
        ip_o, 64'hffff_8000_dddd_0800);
    chk(!rreq, "R11", "no triple after clear", 64'(rreq), 64'd0);

    // R7 fault during flags push
    run_entry(8'd5, 64'h0000_0000_0040_4000, 64'h0200, 64'h5000, 2, -1, 0);
    chk(ip_o == 64'hffff_8000_dddd_0800, "R7", "fault -> double", ip_o, 64'hffff_8000_dddd_0800);
    chk(sp_o == 64'h5000 - 24, "R7", "faulted push suppressed", sp_o, 64'h5000 - 24);

    // plain success after fault run
    run_entry(8'd5, 64'h0000_0000_0040_5000, 64'h0200, 64'h5000, -1, -1, 0);
    chk(ip_o == 64'h5555_0000_aaaa_1111, "R4", "handler vec5", ip_o, 64'h5555_0000_aaaa_1111);

    // R8 fault inside double-fault entry -> halt
    run_entry(8'd14, 64'h0000_0000_0040_6000, 64'h0200, 64'h4000, 2, 6, 0);
    chk(rreq, "R8", "triple reset req", 64'(rreq), 64'd1);
    @(negedge clk); raise = 1; vec = 8'd6;
    repeat (4) @(negedge clk);
    raise = 0;
    chk(rreq && !done && !busy, "R8", "halt holds", {61'b0, rreq, done, busy}, 64'd4);

    // R8 not-present double-fault descriptor -> halt
    rst_n = 0; @(negedge clk); rst_n = 1;
    set_desc(8, 64'h0, 16'h0, 0, 0, 3'd0, 2'd0);
    run_entry(8'd3, 64'h0000_0000_0040_7000, 64'h0200, 64'h3000, -1, -1, 0);
    chk(rreq, "R8", "double not present", 64'(rreq), 64'd1);
    rst_n = 0; @(negedge clk);
    chk(!rreq && !busy, "R1", "reset leaves halt", {62'b0, rreq, busy}, 64'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule